// File: doc/BRIEF.md
# Frequency-Locked Loop Tuning Controller

This block steers a tunable oscillator so that its frequency settles at a fixed multiple of a slow reference clock. It runs on the oscillator's own output (the fast clock). A 16-bit counter runs freely on that clock. Each rising edge of the reference, once synchronized, latches the counter, and the measured interval is the new latch value minus the one before it, taken modulo 2^16. That interval is compared with a programmable target count. After each measurement the tuning word moves one step up, one step down, or stays where it is.

The tuning word has two parts. An 8-bit fine word, made of the oscillator tap plus its modulation bits, sits below a 3-bit coarse range select. An increment that takes the fine word past 255 carries into the range select. A decrement that lands the fine word exactly on zero borrows from it. The range select saturates at both ends. With a 4096 Hz reference, the loop settles at target × 4096 Hz. Target counts below 64 are outside the supported range.

Top module: `fll_tuner`

## Requirements
- R1: While reset is asserted, and right after it is released, the fine word is 0x60 and the range select is 4.
- R2: The first reference rising edge after reset only records a capture. Neither output changes.
- R3: If the measured interval is smaller than the target count, the fine word increases by one.
- R4: If the measured interval is larger than the target count, the fine word decreases by one.
- R5: If the interval equals the target, both outputs hold. The previous capture is still replaced by the current one.
- R6: An increment from 255 wraps the fine word to 0 and raises the range select by one. At 7 the range select holds, and the fine word still wraps.
- R7: A decrement that leaves the fine word at exactly 0 lowers the range select by one. At 0 the range select holds. A decrement from 0 wraps the fine word to 255 and leaves the range select unchanged.
- R8: The interval is the difference of two captures of the free-running 16-bit counter, modulo 2^16. It stays correct across a counter wrap.
- R9: A step shows on the outputs right after the third fast-clock rising edge that follows the edge which first samples the reference high. There is at most one step per reference edge, and the outputs change at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock from the controlled oscillator |
| rst_n | input | 1 | Asynchronous reset, active low |
| refClk | input | 1 | Divided reference clock, asynchronous to clk |
| targetCount | input | 16 | Wanted number of fast cycles per reference period |
| fineWord | output | 8 | Fine tuning word (tap and modulation) |
| rangeSel | output | 3 | Coarse range select |

## Verification
The checker assumes two things. First, reference rising edges are far apart, so a capture is never followed by another capture on the next cycle and one step finishes before the next measurement. Second, the reference is low when reset is released. The stimulus respects both: every reference period is at least 66 fast cycles, and the reference is held low around each reset. The target count is changed only while the reference is low and no step is pending, and every target used is 64 or more. A 66-cycle period against a target of 64 gives a run of decrements. A large target gives a run of increments that lasts long enough for the free-running counter to wrap.

// File: rtl/fll_tune_pkg.sv
package fll_tune_pkg;

  // strobes from the control to the datapath
  typedef struct packed {
    logic capture;    // latch counter, refresh previous capture and interval
    logic primeOnly;  // this capture is the first one after reset
    logic stepUp;     // increment the tuning word
    logic stepDown;   // decrement the tuning word
  } fllStrobe_t;

endpackage

// File: rtl/fll_ref_sync.sv
module fll_ref_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic refClk,
  output logic refRise
);
  logic [STAGES-1:0] chain;
  logic              refDly;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= refClk;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) refDly <= 1'b0;
    else        refDly <= chain[STAGES-1];
  end

  assign refRise = chain[STAGES-1] & ~refDly;
endmodule

// File: rtl/fll_ctrl.sv
module fll_ctrl
  import fll_tune_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       refClk,
  input  logic       cmpLess,
  input  logic       cmpMore,
  output fllStrobe_t stb
);
  logic refRise;
  logic primed;
  logic evalPend;

  fll_ref_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .refClk (refClk),
    .refRise(refRise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed   <= 1'b0;
      evalPend <= 1'b0;
    end else begin
      evalPend <= refRise & primed;
      if (refRise) primed <= 1'b1;
    end
  end

  always_comb begin
    stb.capture   = refRise;
    stb.primeOnly = refRise & ~primed;
    stb.stepUp    = evalPend & cmpLess;
    stb.stepDown  = evalPend & cmpMore;
  end
endmodule

// File: rtl/fll_datapath.sv
module fll_datapath
  import fll_tune_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned FINE_W    = 8,
  parameter int unsigned RANGE_W   = 3,
  parameter int unsigned FINE_RST  = 96,
  parameter int unsigned RANGE_RST = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  fllStrobe_t         stb,
  input  logic [CNT_W-1:0]   targetCount,
  output logic               cmpLess,
  output logic               cmpMore,
  output logic [FINE_W-1:0]  fineWord,
  output logic [RANGE_W-1:0] rangeSel
);
  localparam logic [FINE_W-1:0]  FINE_MAX  = {FINE_W{1'b1}};
  localparam logic [FINE_W-1:0]  FINE_ONE  = FINE_W'(1);
  localparam logic [RANGE_W-1:0] RANGE_MAX = {RANGE_W{1'b1}};

  logic [CNT_W-1:0] freeCnt;
  logic [CNT_W-1:0] prevCap;
  logic [CNT_W-1:0] interval;

  // measurement: free-running counter, captures are differenced
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freeCnt  <= '0;
      prevCap  <= '0;
      interval <= '0;
    end else begin
      freeCnt <= freeCnt + CNT_W'(1);
      if (stb.capture) begin
        prevCap  <= freeCnt;
        interval <= freeCnt - prevCap;
      end
    end
  end

  assign cmpLess = interval < targetCount;
  assign cmpMore = interval > targetCount;

  // tuning word: fine cascades into a saturating range
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fineWord <= FINE_W'(FINE_RST);
      rangeSel <= RANGE_W'(RANGE_RST);
    end else if (stb.stepUp) begin
      fineWord <= fineWord + FINE_ONE;
      if (fineWord == FINE_MAX && rangeSel != RANGE_MAX)
        rangeSel <= rangeSel + RANGE_W'(1);
    end else if (stb.stepDown) begin
      fineWord <= fineWord - FINE_ONE;
      if (fineWord == FINE_ONE && rangeSel != '0)
        rangeSel <= rangeSel - RANGE_W'(1);
    end
  end
endmodule

// File: rtl/fll_tuner.sv
module fll_tuner
  import fll_tune_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned FINE_W      = 8,
  parameter int unsigned RANGE_W     = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FINE_RST    = 96,
  parameter int unsigned RANGE_RST   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               refClk,
  input  logic [CNT_W-1:0]   targetCount,
  output logic [FINE_W-1:0]  fineWord,
  output logic [RANGE_W-1:0] rangeSel
);
  fllStrobe_t ctlStb;
  logic       cmpLess;
  logic       cmpMore;

  fll_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .refClk (refClk),
    .cmpLess(cmpLess),
    .cmpMore(cmpMore),
    .stb    (ctlStb)
  );

  fll_datapath #(
    .CNT_W    (CNT_W),
    .FINE_W   (FINE_W),
    .RANGE_W  (RANGE_W),
    .FINE_RST (FINE_RST),
    .RANGE_RST(RANGE_RST)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (ctlStb),
    .targetCount(targetCount),
    .cmpLess    (cmpLess),
    .cmpMore    (cmpMore),
    .fineWord   (fineWord),
    .rangeSel   (rangeSel)
  );
endmodule

// File: rtl/fll_tuner_chk.sv
module fll_tuner_chk
  import fll_tune_pkg::*;
#(
  parameter int unsigned FINE_W  = 8,
  parameter int unsigned RANGE_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [FINE_W-1:0]  fineWord,
  input logic [RANGE_W-1:0] rangeSel,
  input fllStrobe_t         stb
);
  localparam logic [FINE_W-1:0]  FMAX = {FINE_W{1'b1}};
  localparam logic [RANGE_W-1:0] RMAX = {RANGE_W{1'b1}};

  // input assumption: reference edges are far apart
  assert_ref_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stb.capture |=> !stb.capture);

  assert_single_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.stepUp, stb.stepDown}));

  assert_prime_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stb.primeOnly |=> !(stb.stepUp || stb.stepDown));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.stepUp || stb.stepDown) |=> ($stable(fineWord) && $stable(rangeSel)));

  assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stb.stepUp |=> fineWord == FINE_W'($past(fineWord) + FINE_W'(1)));

  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stb.stepDown |=> fineWord == FINE_W'($past(fineWord) - FINE_W'(1)));

  assert_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.stepUp && fineWord == FMAX) |=>
      (($past(rangeSel) == RMAX) ? (rangeSel == RMAX)
                                 : (rangeSel == RANGE_W'($past(rangeSel) + RANGE_W'(1)))));

  assert_no_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.stepUp && fineWord != FMAX) |=> $stable(rangeSel));

  assert_borrow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.stepDown && fineWord == FINE_W'(1)) |=>
      (($past(rangeSel) == '0) ? (rangeSel == '0)
                               : (rangeSel == RANGE_W'($past(rangeSel) - RANGE_W'(1)))));

  assert_no_borrow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.stepDown && fineWord != FINE_W'(1)) |=> $stable(rangeSel));
endmodule

bind fll_tuner fll_tuner_chk #(.FINE_W(FINE_W), .RANGE_W(RANGE_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .fineWord(fineWord),
  .rangeSel(rangeSel),
  .stb     (ctlStb)
);

// File: tb/fll_tuner_tb_top.sv
module fll_tuner_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        refClk = 1'b0;
  logic [15:0] targetCount = 16'd100;
  logic [7:0]  fineWord;
  logic [2:0]  rangeSel;

  int checks = 0;
  int errors = 0;
  bit cmpOn = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fll_tuner dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .refClk     (refClk),
    .targetCount(targetCount),
    .fineWord   (fineWord),
    .rangeSel   (rangeSel)
  );

  // behavioural reference model
  int mFine = 96;
  int mRange = 4;
  int cyc = 0;
  int lastEdge = 0;
  bit lastRef = 1'b0;
  bit primed = 1'b0;
  int pendAt[$];
  int pendDir[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      mFine = 96; mRange = 4; cyc = 0; lastRef = 1'b0; primed = 1'b0;
      pendAt.delete(); pendDir.delete();
    end else begin
      while (pendAt.size() > 0 && pendAt[0] == cyc) begin
        int d;
        d = pendDir.pop_front();
        void'(pendAt.pop_front());
        if (d > 0) begin
          if (mFine == 255) begin mFine = 0; if (mRange < 7) mRange++; end
          else mFine++;
        end else if (d < 0) begin
          mFine = (mFine + 255) % 256;
          if (mFine == 0 && mRange > 0) mRange--;
        end
      end
      if (refClk && !lastRef) begin
        if (primed) begin
          int iv;
          iv = (cyc - lastEdge) % 65536;
          pendAt.push_back(cyc + 3);
          pendDir.push_back(iv < int'(targetCount) ? 1 : (iv > int'(targetCount) ? -1 : 0));
        end
        lastEdge = cyc;
        primed = 1'b1;
      end
      lastRef = refClk;
      cyc++;
    end
  end

  task automatic chk(string tag, int expF, int expR);
    checks++;
    if (int'(fineWord) != expF || int'(rangeSel) != expR) begin
      errors++;
      $display("FAIL %s fine %0d exp %0d range %0d exp %0d",
               tag, fineWord, expF, rangeSel, expR);
    end
  endtask

  // cycle-exact comparison against the model (R9)
  always @(negedge clk) begin
    if (rst_n && cmpOn) chk("R9", mFine, mRange);
  end

  task automatic refCycle(int period);
    refClk = 1'b1;
    repeat (period / 2) @(negedge clk);
    refClk = 1'b0;
    repeat (period - period / 2) @(negedge clk);
  endtask

  task automatic doReset();
    cmpOn = 1'b0;
    rst_n = 1'b0;
    refClk = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", 96, 4);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 96, 4);
    cmpOn = 1'b1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    doReset();
    // first edge only primes
    targetCount = 16'd100;
    refCycle(100);
    chk("R2", 96, 4);
    // intervals equal to the target
    repeat (6) refCycle(100);
    chk("R5", 96, 4);
    // shorter intervals: first measures 100 (hold), then four increments
    repeat (5) refCycle(90);
    chk("R3", 100, 4);
    // longer intervals: first measures 90 (up), then four decrements
    repeat (5) refCycle(110);
    chk("R4", 97, 4);
    // long run of increments: carries, range saturates at 7, counter wraps
    targetCount = 16'd2000;
    repeat (1000) refCycle(66);
    chk("R6", 73, 7);
    chk("R8", mFine, mRange);
    // reset, then a long run of decrements down to the range floor
    doReset();
    targetCount = 16'd64;
    refCycle(66);
    repeat (96) refCycle(66);
    chk("R7", 0, 3);
    repeat (1034) refCycle(66);
    chk("R7", 246, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule